// File: doc/BRIEF.md
# Endpoint Configuration and Stall Control Register

This block is the per-endpoint control word of a USB device controller that serves up to five non-control endpoints. A CPU writes a 16-bit word to it and reads it back. The word holds the endpoint enable, the transfer type, the direction, the DMA auto-transfer mode, the zero-length auto-send mode, the stall flag and the maximum packet size. The configured values drive the packet engine directly, together with a stall-response request.

The structural fields (enable, type, direction, packet size) can only be changed while the controller reset bit and the endpoint's buffer-init bit are both high. The mode bits and the stall bit are always writable. A write with an illegal type or packet size leaves that field untouched and raises a one-cycle error pulse. The stall bit has two owners, selected by a global mode input. In software mode, only the CPU sets and clears it. In hardware mode, a write of 1 sets it, a write of 0 does nothing, a decoded Clear Feature for this endpoint clears it, and the bit reads back as 0.

The parameter `EP_INDEX` selects between the wide packet-size field of endpoint 1 and the narrow field of endpoints 2 to 5.

Top module: `ep_cfg_reg`

## Requirements
- R1: After reset the read word is 0x6100 for endpoint 1 and 0x6040 for endpoints 2 to 5. That is: enable 0, type 11, direction 0, both modes 0, stall 0, and the packet size at its maximum.
- R2: The read word layout is: bit 15 enable, bits 14:13 type, bit 12 direction (1 = IN), bit 11 DMA mode, bit 10 zero-length mode, bit 9 stall, bits 8:0 packet size. A write updates the read word at the clock edge that samples it.
- R3: Enable, type, direction and packet size change only on a write made while ctlReset and bufInit are both 1. Other writes drop these fields without any error. The DMA-mode and zero-length-mode bits of the same write always take effect.
- R4: Type values 00 and 01 are illegal. An unlocked write with bit 14 = 0 keeps the old type.
- R5: For endpoint 1 the legal packet sizes are 0x001 to 0x100. Any other unlocked size write keeps the old size.
- R6: For endpoints 2 to 5 the legal packet sizes are 0x01 to 0x40. Bits 8:7 of the read word are always 0.
- R7: When bit 11 (DMA mode) of the same write is 1, sizes 0 to 2 are also illegal and are rejected.
- R8: cfgErr is high for exactly the one cycle after the edge of an unlocked write whose type or size is illegal. It stays low for locked and legal writes.
- R9: With stallClrMode = 0, bit 9 of a write sets or clears the stall flag, reads return the flag, and clrFeatureHit has no effect.
- R10: With stallClrMode = 1, a write of 1 to bit 9 sets the flag and a write of 0 has no effect. clrFeatureHit clears the flag, and bit 9 reads as 0. When a set and a clear occur in the same cycle, the set wins.
- R11: stallReq is high exactly when the endpoint is enabled and the stall flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | 16 | CPU write word |
| rdData | output | 16 | CPU read word |
| ctlReset | input | 1 | Controller held in reset (global control bit) |
| bufInit | input | 1 | Endpoint buffer held in init |
| stallClrMode | input | 1 | 1: hardware clears stall on Clear Feature |
| clrFeatureHit | input | 1 | Decoded Clear Feature (halt) for this endpoint |
| epEnable | output | 1 | Endpoint enabled |
| epType | output | 2 | Transfer type (10 bulk, 11 interrupt) |
| epDirIn | output | 1 | Direction, 1 = IN |
| dmaMode | output | 1 | DMA auto-transfer mode |
| zlpMode | output | 1 | Zero-length auto-send mode |
| maxPkt | output | 9 | Maximum packet size |
| stallReq | output | 1 | Respond with STALL |
| cfgErr | output | 1 | One-cycle pulse after an illegal unlocked write |

## Verification
Every register result (the read word, the configured outputs and stallReq) changes at the clock edge that samples the write or the Clear Feature pulse. The error pulse is registered at that same edge and is high for exactly the following cycle. The bench drives each stimulus on a falling edge, lets one rising edge pass, and checks all outputs on the next falling edge. At that point the read word is settled and the error pulse is still in its single high cycle. Expected words come from a behavioural model in the bench, and an extra idle cycle between stimuli confirms that the error pulse has dropped.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;
  // Strobes from the write-decision logic to the register datapath
  typedef struct packed {
    logic ldCore;    // enable and direction
    logic ldType;    // transfer type
    logic ldSize;    // packet size
    logic ldMode;    // DMA and zero-length mode bits
    logic stallSet;
    logic stallClr;
    logic flagErr;
  } epStrobe_t;

  localparam int BIT_EN    = 15;
  localparam int BIT_TYPEH = 14;
  localparam int BIT_DIR   = 12;
  localparam int BIT_DMA   = 11;
  localparam int BIT_ZLP   = 10;
  localparam int BIT_STALL = 9;
  localparam int SIZE_W    = 9;
endpackage

// File: rtl/ep_cfg_ctrl.sv
module ep_cfg_ctrl
  import ep_cfg_pkg::*;
#(
  parameter int MAX_PKT = 256
) (
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        cfgOpen,
  input  logic        stallHwMode,
  input  logic        clrHit,
  output epStrobe_t   strb
);
  logic [SIZE_W-1:0] sizeVal;
  logic              sizeBad;
  logic              typeBad;

  always_comb begin
    sizeVal = wrData[SIZE_W-1:0];
    sizeBad = (sizeVal == '0) || (32'(sizeVal) > MAX_PKT) ||
              (wrData[BIT_DMA] && (sizeVal <= 9'd2));
    typeBad = !wrData[BIT_TYPEH];

    strb.ldCore   = wrEn && cfgOpen;
    strb.ldType   = wrEn && cfgOpen && !typeBad;
    strb.ldSize   = wrEn && cfgOpen && !sizeBad;
    strb.ldMode   = wrEn;
    strb.stallSet = wrEn && wrData[BIT_STALL];
    strb.stallClr = stallHwMode ? (clrHit && !(wrEn && wrData[BIT_STALL]))
                                : (wrEn && !wrData[BIT_STALL]);
    strb.flagErr  = wrEn && cfgOpen && (typeBad || sizeBad);
  end
endmodule

// File: rtl/ep_cfg_dp.sv
module ep_cfg_dp
  import ep_cfg_pkg::*;
#(
  parameter int PKT_W   = 9,
  parameter int MAX_PKT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       wrData,
  input  epStrobe_t         strb,
  input  logic              stallHwMode,
  input  logic              cfgOpen,
  input  logic              wrEn,
  output logic [15:0]       rdData,
  output logic              epEnable,
  output logic [1:0]        epType,
  output logic              epDirIn,
  output logic              dmaMode,
  output logic              zlpMode,
  output logic [SIZE_W-1:0] maxPkt,
  output logic              stallFlag,
  output logic              cfgErr
);
  localparam logic [PKT_W-1:0] RST_SIZE = PKT_W'(MAX_PKT);

  logic [PKT_W-1:0] sizeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epEnable  <= 1'b0;
      epType    <= 2'b11;
      epDirIn   <= 1'b0;
      dmaMode   <= 1'b0;
      zlpMode   <= 1'b0;
      sizeQ     <= RST_SIZE;
      stallFlag <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (strb.ldCore) begin
        epEnable <= wrData[BIT_EN];
        epDirIn  <= wrData[BIT_DIR];
      end
      if (strb.ldType) epType <= wrData[BIT_TYPEH -: 2];
      if (strb.ldSize) sizeQ <= wrData[PKT_W-1:0];
      if (strb.ldMode) begin
        dmaMode <= wrData[BIT_DMA];
        zlpMode <= wrData[BIT_ZLP];
      end
      if (strb.stallSet)      stallFlag <= 1'b1;
      else if (strb.stallClr) stallFlag <= 1'b0;
      cfgErr <= strb.flagErr;
    end
  end

  assign maxPkt = SIZE_W'(sizeQ);
  assign rdData = {epEnable, epType, epDirIn, dmaMode, zlpMode,
                   stallFlag && !stallHwMode, maxPkt};

  // R3: locked fields hold when no unlocked write occurred
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && cfgOpen) |=> $stable(epEnable) && $stable(epType) &&
                           $stable(epDirIn) && $stable(sizeQ));
  // R4: type never holds an illegal code
  p_type_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    epType[1]);
  // R5 / R6: size always inside the legal window
  p_size_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (maxPkt != '0) && (32'(maxPkt) <= MAX_PKT));
endmodule

// File: rtl/ep_cfg_reg.sv
module ep_cfg_reg
  import ep_cfg_pkg::*;
#(
  parameter int EP_INDEX = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        ctlReset,
  input  logic        bufInit,
  input  logic        stallClrMode,
  input  logic        clrFeatureHit,
  output logic        epEnable,
  output logic [1:0]  epType,
  output logic        epDirIn,
  output logic        dmaMode,
  output logic        zlpMode,
  output logic [8:0]  maxPkt,
  output logic        stallReq,
  output logic        cfgErr
);
  localparam int PKT_W   = (EP_INDEX == 1) ? 9 : 7;
  localparam int MAX_PKT = 1 << (PKT_W - 1);

  epStrobe_t strb;
  logic      cfgOpen;
  logic      stallFlag;

  assign cfgOpen = ctlReset && bufInit;

  ep_cfg_ctrl #(.MAX_PKT(MAX_PKT)) ctrl_i (
    .wrEn(wrEn), .wrData(wrData), .cfgOpen(cfgOpen),
    .stallHwMode(stallClrMode), .clrHit(clrFeatureHit), .strb(strb));

  ep_cfg_dp #(.PKT_W(PKT_W), .MAX_PKT(MAX_PKT)) dp_i (
    .clk(clk), .rst_n(rst_n), .wrData(wrData), .strb(strb),
    .stallHwMode(stallClrMode), .cfgOpen(cfgOpen), .wrEn(wrEn),
    .rdData(rdData), .epEnable(epEnable), .epType(epType),
    .epDirIn(epDirIn), .dmaMode(dmaMode), .zlpMode(zlpMode),
    .maxPkt(maxPkt), .stallFlag(stallFlag), .cfgErr(cfgErr));

  assign stallReq = epEnable && stallFlag;

  // R10: hardware clear removes the stall response on the next cycle
  p_hw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stallClrMode && clrFeatureHit && !(wrEn && wrData[9])) |=> !stallReq);
  // R11: stall response only on an enabled endpoint
  p_stall_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stallReq |-> rdData[15]);
  // R8: error pulse only follows a write
  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> $past(wrEn));
endmodule

// File: tb/ep_cfg_reg_tb.sv
module ep_cfg_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        ctlReset = 1'b1, bufInit = 1'b1;
  logic        stallClrMode = 1'b0, clrFeatureHit = 1'b0;

  logic [15:0] rd1, rd2;
  logic        en1, en2, dir1, dir2, dma1, dma2, zlp1, zlp2;
  logic [1:0]  ty1, ty2;
  logic [8:0]  mp1, mp2;
  logic        st1, st2, er1, er2;

  int nChecks = 0, nFails = 0;
  logic [15:0] m1, m2;  // model images, bit 9 = raw stall flag

  always #2 clk = ~clk;  // 250 MHz

  ep_cfg_reg #(.EP_INDEX(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .rdData(rd1),
    .ctlReset(ctlReset), .bufInit(bufInit), .stallClrMode(stallClrMode),
    .clrFeatureHit(clrFeatureHit), .epEnable(en1), .epType(ty1),
    .epDirIn(dir1), .dmaMode(dma1), .zlpMode(zlp1), .maxPkt(mp1),
    .stallReq(st1), .cfgErr(er1));

  ep_cfg_reg #(.EP_INDEX(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .rdData(rd2),
    .ctlReset(ctlReset), .bufInit(bufInit), .stallClrMode(stallClrMode),
    .clrFeatureHit(clrFeatureHit), .epEnable(en2), .epType(ty2),
    .epDirIn(dir2), .dmaMode(dma2), .zlpMode(zlp2), .maxPkt(mp2),
    .stallReq(st2), .cfgErr(er2));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input logic [15:0] cur, input logic [15:0] d,
                                        input logic open, input logic mode, input int maxv);
    logic [15:0] n = cur;
    logic typeOk, sizeOk;
    typeOk = d[14];
    sizeOk = (d[8:0] != 0) && (int'(d[8:0]) <= maxv) && !(d[11] && d[8:0] <= 2);
    if (open) begin
      n[15] = d[15]; n[12] = d[12];
      if (typeOk) n[14:13] = d[14:13];
      if (sizeOk) n[8:0] = d[8:0];
    end
    n[11] = d[11]; n[10] = d[10];
    if (mode) begin if (d[9]) n[9] = 1'b1; end
    else n[9] = d[9];
    return {open && !(typeOk && sizeOk), n};
  endfunction

  function automatic logic [15:0] rdView(input logic [15:0] img);
    logic [15:0] r = img;
    r[9] = img[9] && !stallClrMode;
    return r;
  endfunction

  task automatic checkAll(input string req, input logic e1, input logic e2);
    chk(req, rd1, rdView(m1));
    chk(req, rd2, rdView(m2));
    chk({req, " err"}, {15'd0, er1}, {15'd0, e1});
    chk({req, " err"}, {15'd0, er2}, {15'd0, e2});
    chk("R11", {15'd0, st1}, {15'd0, m1[15] & m1[9]});
    chk("R11", {15'd0, st2}, {15'd0, m2[15] & m2[9]});
    chk("R6", {14'd0, rd2[8:7]}, 16'd0);
  endtask

  task automatic doWrite(input string req, input logic [15:0] d);
    logic [16:0] r1, r2;
    r1 = model(m1, d, ctlReset && bufInit, stallClrMode, 256);
    r2 = model(m2, d, ctlReset && bufInit, stallClrMode, 64);
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    m1 = r1[15:0]; m2 = r2[15:0];
    checkAll(req, r1[16], r2[16]);
    @(negedge clk);
    chk("R8 drop", {14'd0, er1, er2}, 16'd0);
  endtask

  task automatic doClear(input string req);
    clrFeatureHit = 1'b1;
    @(negedge clk);
    clrFeatureHit = 1'b0;
    if (stallClrMode) begin m1[9] = 1'b0; m2[9] = 1'b0; end
    checkAll(req, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    m1 = 16'h6100; m2 = 16'h6040;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1", rd1, 16'h6100);
    chk("R1", rd2, 16'h6040);
    checkAll("R1", 1'b0, 1'b0);

    // R4 / R2: type sweep with legal size, direction toggled
    for (int t = 0; t < 4; t++) doWrite("R4", {1'b1, 2'(t), 1'(t), 3'b000, 9'h010});

    // R5 / R6: full size sweep, DMA off
    for (int v = 0; v < 512; v++) doWrite("R5", {4'b1100, 3'b000, 9'(v)});

    // R7: DMA on, small sizes
    for (int v = 0; v < 6; v++) doWrite("R7", {4'b1100, 3'b100, 9'(v)});
    doWrite("R7", 16'hC805);

    // R3: locked writes; mode bits still apply, no error even if illegal
    ctlReset = 1'b0;
    doWrite("R3", 16'h1C20);
    doWrite("R3", 16'h0000);
    ctlReset = 1'b1; bufInit = 1'b0;
    doWrite("R3", 16'h9480);
    bufInit = 1'b1;
    doWrite("R3", 16'hD020);

    // R9: software-owned stall
    stallClrMode = 1'b0;
    doWrite("R9", 16'hD220);
    doClear("R9");
    doWrite("R9", 16'hD020);
    doWrite("R9 R11", 16'h5220);
    doWrite("R9 R11", 16'hD220);
    doWrite("R9", 16'hD020);

    // R10: hardware-cleared stall
    stallClrMode = 1'b1;
    doWrite("R10", 16'hD220);
    doWrite("R10", 16'hD020);
    doClear("R10");
    doWrite("R10", 16'hD220);
    clrFeatureHit = 1'b1;  // set and clear together: set wins
    doWrite("R10", 16'hD220);
    clrFeatureHit = 1'b0;
    doClear("R10");
    // bring the flag out by returning to software mode
    doWrite("R10", 16'hD220);
    stallClrMode = 1'b0;
    @(negedge clk);
    checkAll("R10", 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule